// File: doc/BRIEF.md
# Banked Cartridge Mapper with RAM / Clock Window

This block sits between an 8-bit processor bus with a 16-bit address and a cartridge's ROM and RAM. The lower 16 KB of the address space reads a fixed ROM region. The next 16 KB reads a ROM bank picked by a 7-bit bank register. The upper 8 KB window at 0xA000–0xBFFF is shared. One select register points it at one of four RAM banks or at one of five time-of-day registers. A single enable flag opens or closes the window for both targets.

Software programs the mapper by writing to the ROM address range. Writes there never reach ROM. Each 8 KB slice of 0x0000–0x7FFF is a control register: enable, ROM bank, window select and clock snapshot. The mapper drives a physical ROM address for every ROM read and a RAM address for the window. It holds the RAM storage itself.

The clock set has live registers and a snapshot copy. Reads return the snapshot. Writes change the live set. An optional once-per-second tick advances the live time unless it is halted.

Top module: `bank_mapper`

## Requirements
- R1: A write to 0x0000–0x1FFF sets the window enable when data bits [3:0] equal 0xA, and clears it for any other data.
- R2: A write to 0x2000–0x3FFF of 0x00 sets the ROM bank to 1. Any other byte sets the bank to its low 7 bits, so 0x80 gives bank 0.
- R3: For an address below 0x4000, `rom_addr` equals the address. For 0x4000–0x7FFF, `rom_addr` is bank × 0x4000 + (address − 0x4000).
- R4: A write to 0x4000–0x5FFF decodes the data byte as follows:
  - 0x00–0x03 points the window at that RAM bank.
  - 0x08–0x0C points it at clock register data − 8.
  - Any other value leaves the window target, the RAM bank and the clock index unchanged.
- R5: `ram_addr` is RAM bank × 0x2000 + (address − 0xA000). With the window enabled and RAM selected, window writes store bytes and window reads return them. Storage keeps the offset bits below RAM_KEEP_W, so offsets that differ only above those bits share a byte.
- R6: `rdata` is 0xFF when `rd_en` is low, when the address is outside 0xA000–0xBFFF, when the enable is clear, or when no target has been selected. A window write made while the window is closed changes nothing.
- R7: After reset no window target is selected, the ROM bank is 1, the enable is clear and all clock registers are zero.
- R8: The clock register indices are 0 seconds (6 bits), 1 minutes (6 bits), 2 hours (5 bits), 3 day bits [7:0], and 4 day control. Day control has bit 0 = day bit 8, bit 6 = halt and bit 7 = day overflow. Unused bits read as 0.
- R9: Writing 0x00 and then 0x01 to 0x6000–0x7FFF, as two back-to-back writes to that range, copies the live clock registers into the snapshot. Clock reads return the snapshot. Clock writes change only the live registers.
- R10: A `tick` pulse with halt clear advances the live time:
  - Seconds at 59 wrap to 0 and carry into minutes; any other seconds value counts up modulo 64.
  - Minutes at 59 wrap to 0 and carry into hours; any other minutes value counts up modulo 64.
  - Hours at 23 wrap to 0 and carry into the day counter; any other hours value counts up modulo 32.
  - With halt set, a tick changes nothing.
  - In a cycle with a clock register write, the tick is ignored.
- R11: A day counter at 511 wraps to 0 on advance and sets the day overflow bit. The overflow bit stays set until software writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Bus write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| tick | input | 1 | One-second advance pulse for the live clock |
| rdata | output | 8 | Window read data, 0xFF when closed |
| rom_addr | output | BANK_W+14 | Physical ROM byte address |
| ram_addr | output | RAM_BANK_W+13 | RAM byte address for the window |

## Verification
The bench uses the default parameters: a 7-bit ROM bank, four RAM banks and RAM_KEEP_W = 8. With RAM_KEEP_W = 8, each bank stores 256 bytes. Random 13-bit window offsets therefore alias, and later reads hit bytes written through other offsets. The 7-bit bank width lets directed writes of 0x00, 0x80 and 0xFF reach the bank substitution and truncation corners. Loading seconds, minutes and hours to their wrap values and day to 511 lets a single tick walk the whole carry chain into the overflow bit.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    typedef enum logic [1:0] {
        MAP_NONE = 2'd0,
        MAP_RAM  = 2'd1,
        MAP_CLK  = 2'd2
    } map_sel_e;

    // addr[15:13] slices used by the decoder
    localparam logic [2:0] SLICE_ENABLE = 3'd0;
    localparam logic [2:0] SLICE_BANK   = 3'd1;
    localparam logic [2:0] SLICE_SELECT = 3'd2;
    localparam logic [2:0] SLICE_LATCH  = 3'd3;
    localparam logic [2:0] SLICE_WINDOW = 3'd5;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hrs;
        logic [8:0] day;
        logic       halt;
        logic       ovf;
    } tod_t;

endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
    import bank_mapper_pkg::*;
#(
    parameter int BANK_W     = 7,
    parameter int RAM_BANK_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            slice,
    input  logic [7:0]            wdata,
    output logic                  win_en,
    output logic [BANK_W-1:0]     rom_bank,
    output map_sel_e              map_sel,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic [2:0]            clk_idx,
    output logic                  snap_pulse
);

    typedef struct packed {
        logic                  en;
        logic [BANK_W-1:0]     bank;
        map_sel_e              sel;
        logic [RAM_BANK_W-1:0] rbank;
        logic [2:0]            cidx;
        logic                  armed;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  sel_ram_code, sel_clk_code;

    always_comb begin
        sel_ram_code = (wdata[7:RAM_BANK_W] == '0);
        sel_clk_code = (wdata >= 8'h08) && (wdata <= 8'h0C);
        ctrl_d       = ctrl_q;
        snap_pulse   = 1'b0;
        if (wr_en) begin
            case (slice)
                SLICE_ENABLE: ctrl_d.en = (wdata[3:0] == 4'hA);
                SLICE_BANK:   ctrl_d.bank = (wdata == 8'h00) ? BANK_W'(1) : BANK_W'(wdata);
                SLICE_SELECT: begin
                    if (sel_ram_code) begin
                        ctrl_d.sel   = MAP_RAM;
                        ctrl_d.rbank = wdata[RAM_BANK_W-1:0];
                    end else if (sel_clk_code) begin
                        ctrl_d.sel  = MAP_CLK;
                        ctrl_d.cidx = wdata[2:0];
                    end
                end
                SLICE_LATCH: begin
                    ctrl_d.armed = (wdata == 8'h00);
                    snap_pulse   = ctrl_q.armed && (wdata == 8'h01);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{en: 1'b0, bank: BANK_W'(1), sel: MAP_NONE,
                        rbank: '0, cidx: '0, armed: 1'b0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign win_en   = ctrl_q.en;
    assign rom_bank = ctrl_q.bank;
    assign map_sel  = ctrl_q.sel;
    assign ram_bank = ctrl_q.rbank;
    assign clk_idx  = ctrl_q.cidx;

    AST_ENABLE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slice == SLICE_ENABLE) |=> (win_en == ($past(wdata[3:0]) == 4'hA))); // R1
    AST_BANK_ZERO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slice == SLICE_BANK && wdata == 8'h00) |=> (rom_bank == BANK_W'(1))); // R2
    AST_SELECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && slice == SLICE_SELECT && !sel_ram_code && !sel_clk_code)
        |=> ($stable(map_sel) && $stable(ram_bank) && $stable(clk_idx))); // R4

endmodule

// File: rtl/mapper_clock.sv
module mapper_clock
    import bank_mapper_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr,
    input  logic [2:0] idx,
    input  logic [7:0] wdata,
    input  logic       snap,
    output logic [7:0] rd_data
);

    localparam logic [5:0] SEC_TOP = 6'd59;
    localparam logic [5:0] MIN_TOP = 6'd59;
    localparam logic [4:0] HRS_TOP = 5'd23;
    localparam logic [8:0] DAY_TOP = 9'd511;

    typedef struct packed {
        tod_t live;
        tod_t held;
    } clk_state_t;

    clk_state_t st_d, st_q;

    function automatic logic [7:0] view(tod_t t, logic [2:0] i);
        case (i)
            3'd0:    view = {2'b00, t.sec};
            3'd1:    view = {2'b00, t.min};
            3'd2:    view = {3'b000, t.hrs};
            3'd3:    view = t.day[7:0];
            3'd4:    view = {t.ovf, t.halt, 5'b00000, t.day[8]};
            default: view = 8'hFF;
        endcase
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (idx)
                3'd0: st_d.live.sec = wdata[5:0];
                3'd1: st_d.live.min = wdata[5:0];
                3'd2: st_d.live.hrs = wdata[4:0];
                3'd3: st_d.live.day[7:0] = wdata;
                3'd4: begin
                    st_d.live.day[8] = wdata[0];
                    st_d.live.halt   = wdata[6];
                    st_d.live.ovf    = wdata[7];
                end
                default: ;
            endcase
        end else if (tick && !st_q.live.halt) begin
            if (st_q.live.sec != SEC_TOP) begin
                st_d.live.sec = st_q.live.sec + 6'd1;
            end else begin
                st_d.live.sec = '0;
                if (st_q.live.min != MIN_TOP) begin
                    st_d.live.min = st_q.live.min + 6'd1;
                end else begin
                    st_d.live.min = '0;
                    if (st_q.live.hrs != HRS_TOP) begin
                        st_d.live.hrs = st_q.live.hrs + 5'd1;
                    end else begin
                        st_d.live.hrs = '0;
                        if (st_q.live.day != DAY_TOP) begin
                            st_d.live.day = st_q.live.day + 9'd1;
                        end else begin
                            st_d.live.day = '0;
                            st_d.live.ovf = 1'b1;
                        end
                    end
                end
            end
        end
        if (snap) begin
            st_d.held = st_q.live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = view(st_q.held, idx);

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && st_q.live.halt) |=> $stable(st_q.live)); // R10
    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (st_q.held == $past(st_q.live))); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && st_q.live.ovf) |=> st_q.live.ovf); // R11

endmodule

// File: rtl/mapper_ram.sv
module mapper_ram #(
    parameter int RAM_BANK_W = 2,
    parameter int KEEP_W     = 8
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [RAM_BANK_W-1:0] bank,
    input  logic [KEEP_W-1:0]     ofs,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata
);

    localparam int IDX_W = RAM_BANK_W + KEEP_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0]       mem_q [DEPTH];
    logic [IDX_W-1:0] idx;

    assign idx = {bank, ofs};

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int BANK_W     = 7,
    parameter int RAM_BANK_W = 2,
    parameter int RAM_KEEP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [15:0]              addr,
    input  logic [7:0]               wdata,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     tick,
    output logic [7:0]               rdata,
    output logic [BANK_W+13:0]       rom_addr,
    output logic [RAM_BANK_W+12:0]   ram_addr
);

    logic                  win_en;
    logic [BANK_W-1:0]     rom_bank;
    map_sel_e              map_sel;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic [2:0]            clk_idx;
    logic                  snap_pulse;
    logic [2:0]            slice;
    logic                  in_win, win_open, ram_we, clk_we;
    logic [7:0]            ram_rd, clk_rd;

    assign slice    = addr[15:13];
    assign in_win   = (slice == SLICE_WINDOW);
    assign win_open = win_en && (map_sel != MAP_NONE);
    assign ram_we   = wr_en && in_win && win_en && (map_sel == MAP_RAM);
    assign clk_we   = wr_en && in_win && win_en && (map_sel == MAP_CLK);

    mapper_ctrl #(.BANK_W(BANK_W), .RAM_BANK_W(RAM_BANK_W)) i_ctrl (
        .clk, .rst_n, .wr_en, .slice, .wdata,
        .win_en, .rom_bank, .map_sel, .ram_bank, .clk_idx, .snap_pulse
    );

    mapper_clock i_clock (
        .clk, .rst_n, .tick, .wr(clk_we), .idx(clk_idx), .wdata,
        .snap(snap_pulse), .rd_data(clk_rd)
    );

    mapper_ram #(.RAM_BANK_W(RAM_BANK_W), .KEEP_W(RAM_KEEP_W)) i_ram (
        .clk, .we(ram_we), .bank(ram_bank), .ofs(addr[RAM_KEEP_W-1:0]),
        .wdata, .rdata(ram_rd)
    );

    always_comb begin
        rdata = 8'hFF;
        if (rd_en && in_win && win_open) begin
            rdata = (map_sel == MAP_RAM) ? ram_rd : clk_rd;
        end
        rom_addr = addr[14] ? {rom_bank, addr[13:0]} : {{BANK_W{1'b0}}, addr[13:0]};
        ram_addr = {ram_bank, addr[12:0]};
    end

    AST_CLOSED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && in_win && !win_en) |-> (rdata == 8'hFF)); // R6
    AST_LOW_ROM_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:14] == 2'b00) |-> (rom_addr == (BANK_W+14)'(addr))); // R3

endmodule

// File: tb/test_bank_mapper.sv
module test_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
    logic [7:0]  rdata;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;

    int total = 0, bad = 0;
    bit done = 0;

    bank_mapper i_bank_mapper (
        .clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .tick,
        .rdata, .rom_addr, .ram_addr
    );

    always #10 clk = ~clk;

    // reference state
    typedef struct { int sec, min, hrs, day; bit halt, ovf; } tod_m;
    bit       m_en, m_armed;
    int       m_bank, m_sel, m_rbank, m_cidx;   // m_sel: 0 none, 1 ram, 2 clock
    tod_m     live, held;
    bit [7:0] mram [1024];
    bit       mok  [1024];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int view(tod_m t, int i);
        case (i)
            0: return t.sec;
            1: return t.min;
            2: return t.hrs;
            3: return t.day & 255;
            4: return (int'(t.ovf) << 7) | (int'(t.halt) << 6) | (t.day >> 8);
            default: return 255;
        endcase
    endfunction

    function automatic void model_write(bit [15:0] a, bit [7:0] d);
        case (a[15:13])
            3'd0: m_en = (d[3:0] == 4'hA);
            3'd1: m_bank = (d == 0) ? 1 : (d & 8'h7F);
            3'd2: begin
                if (d <= 3) begin m_sel = 1; m_rbank = d; end
                else if (d >= 8 && d <= 12) begin m_sel = 2; m_cidx = d - 8; end
            end
            3'd3: begin
                if (m_armed && d == 1) held = live;
                m_armed = (d == 0);
            end
            3'd5: begin
                if (m_en && m_sel == 1) begin
                    mram[m_rbank*256 + a[7:0]] = d;
                    mok[m_rbank*256 + a[7:0]] = 1;
                end else if (m_en && m_sel == 2) begin
                    case (m_cidx)
                        0: live.sec = d & 63;
                        1: live.min = d & 63;
                        2: live.hrs = d & 31;
                        3: live.day = (live.day & 256) | d;
                        4: begin live.day = (live.day & 255) | (int'(d[0]) << 8);
                                 live.halt = d[6]; live.ovf = d[7]; end
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
    endfunction

    function automatic void model_tick();
        if (live.halt) return;
        if (live.sec != 59) begin live.sec = (live.sec + 1) & 63; return; end
        live.sec = 0;
        if (live.min != 59) begin live.min = (live.min + 1) & 63; return; end
        live.min = 0;
        if (live.hrs != 23) begin live.hrs = (live.hrs + 1) & 31; return; end
        live.hrs = 0;
        if (live.day != 511) live.day++;
        else begin live.day = 0; live.ovf = 1; end
    endfunction

    task automatic bus_wr(input bit [15:0] a, input bit [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk);
        #1 wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_rd(input bit [15:0] a, input string tag);
        int exp;
        bit known;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        known = 1; exp = 255;
        if (a[15:13] == 3'd5 && m_en && m_sel != 0) begin
            if (m_sel == 1) begin
                known = mok[m_rbank*256 + a[7:0]];
                exp = mram[m_rbank*256 + a[7:0]];
            end else begin
                exp = view(held, m_cidx);
            end
        end
        if (known) chk(tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #1 tick = 1'b0;
        model_tick();
    endtask

    task automatic addr_chk(input bit [15:0] a);
        int exp_rom;
        @(negedge clk);
        addr = a;
        #1;
        exp_rom = a[14] ? (m_bank * 16384 + a[13:0]) : a[13:0];
        chk("R3 rom_addr", rom_addr, exp_rom);
        chk("R5 ram_addr", ram_addr, m_rbank * 8192 + a[12:0]);
    endtask

    task automatic snap();
        bus_wr(16'h6000, 8'h00);
        bus_wr(16'h7FFF, 8'h01);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_armed = 0; m_bank = 1; m_sel = 0; m_rbank = 0; m_cidx = 0;
        live = '{0, 0, 0, 0, 0, 0}; held = live;
        foreach (mok[i]) mok[i] = 0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7 reset state
        bus_rd(16'hA000, "R7 window closed at reset");
        addr_chk(16'h4123);                       // R7 bank is 1
        bus_wr(16'h0000, 8'h0A);
        bus_rd(16'hA010, "R7 enabled but nothing selected");

        // R2 bank corners
        bus_wr(16'h2000, 8'h00); addr_chk(16'h7FFF);
        bus_wr(16'h3FFF, 8'hFF); addr_chk(16'h4000);
        bus_wr(16'h2100, 8'h80); addr_chk(16'h5555);
        addr_chk(16'h1234);                       // R3 fixed lower window

        // R1 enable nibble, R6 closed write ignored
        bus_wr(16'h4000, 8'h02);
        bus_wr(16'hA005, 8'h5C);
        bus_wr(16'h1FFF, 8'h3B);                  // R1 closes
        bus_rd(16'hA005, "R1 closed by nibble B");
        bus_wr(16'hA005, 8'hEE);                  // R6 ignored
        bus_wr(16'h0100, 8'h1A);                  // R1 opens by nibble
        bus_rd(16'hA005, "R6 closed write ignored");
        @(negedge clk); addr = 16'hA005; rd_en = 1'b0; #1;
        chk("R6 rd_en low", rdata, 255);
        bus_rd(16'h8005, "R6 outside window");

        // R5 banks and aliasing
        for (int b = 0; b < 4; b++) begin
            bus_wr(16'h4000, 8'(b));
            bus_wr(16'hA000 + 16'(b * 3), 8'(8'h30 + b));
        end
        for (int b = 0; b < 4; b++) begin
            bus_wr(16'h4000, 8'(b));
            bus_rd(16'hA000 + 16'(b * 3), "R5 bank readback");
            bus_rd(16'hA100 + 16'(b * 3), "R5 offset alias");
            addr_chk(16'hBFFF);
        end

        // R4 illegal select keeps RAM bank 3
        bus_wr(16'h4000, 8'h05);
        bus_wr(16'h4000, 8'h0D);
        bus_rd(16'hA009, "R4 illegal select ignored");
        addr_chk(16'hA001);

        // R8 clock layout
        bus_wr(16'h4000, 8'h08); bus_wr(16'hA000, 8'hFF);
        bus_wr(16'h4000, 8'h0A); bus_wr(16'hA000, 8'hFF);
        bus_wr(16'h4000, 8'h0C); bus_wr(16'hA000, 8'hFF);
        snap();
        bus_rd(16'hA000, "R8 day control bits");
        bus_wr(16'h4000, 8'h0A); bus_rd(16'hA000, "R8 hours width");
        bus_wr(16'h4000, 8'h08); bus_rd(16'hA000, "R8 seconds width");

        // R9 snapshot semantics
        bus_wr(16'hA000, 8'd10); snap();
        bus_rd(16'hA000, "R9 snapshot value");
        bus_wr(16'hA000, 8'd20);
        bus_rd(16'hA000, "R9 live write hidden");
        bus_wr(16'h6000, 8'h01);
        bus_rd(16'hA000, "R9 lone 01 no copy");
        snap();
        bus_rd(16'hA000, "R9 recopy");

        // R10/R11 full carry chain
        bus_wr(16'hA000, 8'd59);
        bus_wr(16'h4000, 8'h09); bus_wr(16'hA000, 8'd59);
        bus_wr(16'h4000, 8'h0A); bus_wr(16'hA000, 8'd23);
        bus_wr(16'h4000, 8'h0B); bus_wr(16'hA000, 8'hFF);
        bus_wr(16'h4000, 8'h0C); bus_wr(16'hA000, 8'h01);
        pulse_tick(); snap();
        bus_rd(16'hA000, "R11 overflow set and day wrapped");
        bus_wr(16'h4000, 8'h08);
        bus_rd(16'hA000, "R10 seconds wrapped");
        pulse_tick(); pulse_tick(); snap();
        bus_rd(16'hA000, "R10 seconds counting");
        bus_wr(16'h4000, 8'h0C); bus_rd(16'hA000, "R11 overflow sticky");
        bus_wr(16'hA000, 8'h40);                  // halt
        bus_wr(16'h4000, 8'h08);
        pulse_tick(); pulse_tick(); snap();
        bus_rd(16'hA000, "R10 halt freezes");

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int op;
            bit [15:0] a;
            bit [7:0]  d;
            op = $urandom_range(0, 11);
            d  = 8'($urandom);
            a  = 16'hA000 | 16'($urandom_range(0, 8191));
            case (op)
                0: bus_wr(16'($urandom_range(0, 16'h1FFF)), ($urandom_range(0, 1) != 0) ? 8'h0A : d);
                1: bus_wr(16'h2000 | 16'($urandom_range(0, 8191)), d);
                2: bus_wr(16'h4000, ($urandom_range(0, 2) != 0) ? 8'($urandom_range(0, 13)) : d);
                3: bus_wr(16'h6000, 8'($urandom_range(0, 2)));
                4, 5: bus_wr(a, d);
                6, 7, 8: bus_rd(a, "R5 random window read");
                9: pulse_tick();
                default: addr_chk(16'($urandom_range(0, 16'h7FFF)));
            endcase
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule